// File: doc/BRIEF.md
# Staged Four-Channel DAC Register Front End

This block sits between a 16-bit register bus and four 12-bit digital-to-analog converter channels. It holds the code for each channel and a range setting (extra gain and bipolar select) for each channel, and drives those values to the converter side. Analog conversion is done elsewhere. The block only decides which code and which range each channel presents, and when.

Each channel code can be updated in one of two ways. In direct mode a data write reaches its channel output one clock later. In staged mode data writes only fill holding registers, and a bus read of the mode register moves all four held codes to the outputs on the same edge, so the channels change together. Range settings are always staged: a write to the range register has no effect until a bus read of that same register commits it. A global output-enable forces every code output to zero without losing any stored value.

Top module: `dac_regfront`

## Requirements
- R1: While `rst_n` is low at a clock edge, the mode register, the staged and active range registers and all holding and output codes are cleared. After that edge `dac_code`, `dac_gain` and `dac_bipolar` are all zero.
- R2: Byte address 0x02 is the mode register, 0x12 is the range register, and channel c's data register is at 0x14 + 2·c (c = 0..3). A write to any other address changes no output and no stored value.
- R3: In the mode register, bit 1 is output-enable and bit 0 selects staged mode (1) or direct mode (0). A write stores both bits, and the other bits are ignored.
- R4: In direct mode with output-enable set, a data write to channel c appears on that channel's 12-bit slice of `dac_code` (bits 12·c+11 down to 12·c) after the next rising edge.
- R5: Only bits 11:0 of a data write are stored. Bits 15:12 have no effect on any output.
- R6: In staged mode a data write changes no output.
- R7: In staged mode a bus read of address 0x02 copies all four held codes to the outputs at the same edge, including codes written while output-enable was low.
- R8: While output-enable is low every code output is zero. Clearing and then setting output-enable again shows the codes that were presented before.
- R9: In the range register, bit 11−c selects extra gain and bit 7−c selects bipolar for channel c. `dac_gain[c]` and `dac_bipolar[c]` change only after a bus read of 0x12, which makes them show the last value written there.
- R10: A bus read of any address other than 0x02 and 0x12 changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 8 | Byte address of the current access |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe; reads of 0x02 and 0x12 act as commit strobes |
| bus_wdata | input | 16 | Write data |
| dac_code | output | 48 | Four 12-bit channel codes, channel 0 in the low bits |
| dac_gain | output | 4 | Per-channel extra-gain select, bit c for channel c |
| dac_bipolar | output | 4 | Per-channel bipolar select, bit c for channel c |

## Verification
The bench builds the block with its default parameters: four channels, 12-bit codes, a 16-bit bus and 8-bit addresses. With four channels every range bit position is exercised, from 11 down to 8 for gain and from 7 down to 4 for bipolar. A 16-bit bus against 12-bit codes leaves four upper data bits whose truncation can be observed. The fixed address map places channel 3's data register at 0x1A, so a directed write there and scattered writes to unmapped addresses check the decode boundaries. Runs mixing direct and staged mode with commit reads and enable toggles cover the hand-over between modes while codes are still pending.

// File: rtl/dac_regfront_pkg.sv
// Package: shared address map, bit positions and mode type for the DAC
// register front end. Addresses are byte offsets on the register bus.
package dac_regfront_pkg;

    localparam int MODE_ADDR  = 8'h02;  // mode register, read = code commit
    localparam int RANGE_ADDR = 8'h12;  // range register, read = range commit
    localparam int DATA_BASE  = 8'h14;  // channel 0 data, +2 per channel

    localparam int EN_BIT     = 1;      // output-enable bit in mode register
    localparam int STAGE_BIT  = 0;      // staged-mode bit in mode register
    localparam int GAIN_TOP   = 11;     // gain bit of channel c is GAIN_TOP-c
    localparam int BIP_TOP    = 7;      // bipolar bit of channel c is BIP_TOP-c

    typedef struct packed {
        logic enable;
        logic staged;
    } mode_t;

endpackage

// File: rtl/dac_bus_decode.sv
// Module: dac_bus_decode
// Turns one bus access per cycle into per-register strobes. Purely
// combinational; assumes bus_wr and bus_rd are qualified by the caller.
module dac_bus_decode
    import dac_regfront_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic              wr_mode,
    output logic              wr_range,
    output logic [NUM_CH-1:0] wr_chan,
    output logic              rd_code_commit,
    output logic              rd_range_commit
);

    // Register strobes for the two control registers.
    always_comb begin
        wr_mode         = bus_wr && (bus_addr == ADDR_W'(MODE_ADDR));
        wr_range        = bus_wr && (bus_addr == ADDR_W'(RANGE_ADDR));
        rd_code_commit  = bus_rd && (bus_addr == ADDR_W'(MODE_ADDR));
        rd_range_commit = bus_rd && (bus_addr == ADDR_W'(RANGE_ADDR));
    end

    // One data-register write strobe per channel, two bytes apart.
    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan_dec
        assign wr_chan[c] = bus_wr && (bus_addr == ADDR_W'(DATA_BASE + 2 * c));
    end

endmodule

// File: rtl/dac_mode_reg.sv
// Module: dac_mode_reg
// Holds the output-enable and staged-mode bits. Assumes synchronous
// active-low reset; bits other than the two mode bits are discarded.
module dac_mode_reg
    import dac_regfront_pkg::*;
#(
    parameter int BUS_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_mode,
    input  logic [BUS_W-1:0] wdata,
    output mode_t            mode_q
);

    // Capture the two mode bits on a mode-register write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else if (wr_mode) begin
            mode_q.enable <= wdata[EN_BIT];
            mode_q.staged <= wdata[STAGE_BIT];
        end
    end

endmodule

// File: rtl/dac_channel.sv
// Module: dac_channel
// One channel: a holding register and a presented register. Direct mode
// passes writes straight to the presented register; staged mode moves
// the held code on a commit. Output is zero while enable is low.
module dac_channel #(
    parameter int CODE_W = 12,
    parameter int BUS_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [BUS_W-1:0]  wdata,
    input  logic              staged,
    input  logic              commit,
    input  logic              enable,
    output logic [CODE_W-1:0] code
);

    logic [CODE_W-1:0] hold_q;
    logic [CODE_W-1:0] live_q;

    // Holding register keeps the low code bits of every data write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (wr) begin
            hold_q <= wdata[CODE_W-1:0];
        end
    end

    // Presented register: direct write, or staged commit of the held code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_q <= '0;
        end else if (wr && !staged) begin
            live_q <= wdata[CODE_W-1:0];
        end else if (commit && staged) begin
            live_q <= hold_q;
        end
    end

    // Output gate: forced to zero while the outputs are disabled.
    always_comb begin
        code = enable ? live_q : '0;
    end

endmodule

// File: rtl/dac_range_ctl.sv
// Module: dac_range_ctl
// Staged and active range registers. A write fills the staged copy and a
// commit read copies it to the active one, which drives the per-channel
// gain and bipolar selects. Assumes NUM_CH <= 4 so the fields do not overlap.
module dac_range_ctl
    import dac_regfront_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int BUS_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_range,
    input  logic              commit,
    input  logic [BUS_W-1:0]  wdata,
    output logic [NUM_CH-1:0] gain,
    output logic [NUM_CH-1:0] bipolar
);

    logic [BUS_W-1:0] staged_q;
    logic [BUS_W-1:0] active_q;

    // Staged copy follows writes to the range register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            staged_q <= '0;
        end else if (wr_range) begin
            staged_q <= wdata;
        end
    end

    // Active copy takes the staged value on a commit read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= '0;
        end else if (commit) begin
            active_q <= staged_q;
        end
    end

    // Per-channel field extraction, counting down from the top bits.
    for (genvar c = 0; c < NUM_CH; c++) begin : g_range_bits
        assign gain[c]    = active_q[GAIN_TOP - c];
        assign bipolar[c] = active_q[BIP_TOP - c];
    end

endmodule

// File: rtl/dac_regfront.sv
// Module: dac_regfront
// Top of the DAC register front end: decode, mode register, per-channel
// code registers and range control. One bus access per cycle is assumed;
// reads have no data, they only act as commit strobes.
module dac_regfront
    import dac_regfront_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CODE_W = 12,
    parameter int BUS_W  = 16,
    parameter int ADDR_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic                     bus_wr,
    input  logic                     bus_rd,
    input  logic [BUS_W-1:0]         bus_wdata,
    output logic [NUM_CH*CODE_W-1:0] dac_code,
    output logic [NUM_CH-1:0]        dac_gain,
    output logic [NUM_CH-1:0]        dac_bipolar
);

    logic              wr_mode;
    logic              wr_range;
    logic [NUM_CH-1:0] wr_chan;
    logic              rd_code_commit;
    logic              rd_range_commit;
    mode_t             mode_q;
    logic              out_enable;
    logic              staged_mode;

    dac_bus_decode #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W)
    ) u_decode (
        .bus_addr        (bus_addr),
        .bus_wr          (bus_wr),
        .bus_rd          (bus_rd),
        .wr_mode         (wr_mode),
        .wr_range        (wr_range),
        .wr_chan         (wr_chan),
        .rd_code_commit  (rd_code_commit),
        .rd_range_commit (rd_range_commit)
    );

    dac_mode_reg #(
        .BUS_W (BUS_W)
    ) u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_mode (wr_mode),
        .wdata   (bus_wdata),
        .mode_q  (mode_q)
    );

    // Flatten the mode fields for the channels and the checker.
    always_comb begin
        out_enable  = mode_q.enable;
        staged_mode = mode_q.staged;
    end

    // One code path per channel.
    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        dac_channel #(
            .CODE_W (CODE_W),
            .BUS_W  (BUS_W)
        ) u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr     (wr_chan[c]),
            .wdata  (bus_wdata),
            .staged (staged_mode),
            .commit (rd_code_commit),
            .enable (out_enable),
            .code   (dac_code[c*CODE_W +: CODE_W])
        );
    end

    dac_range_ctl #(
        .NUM_CH (NUM_CH),
        .BUS_W  (BUS_W)
    ) u_range (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_range (wr_range),
        .commit   (rd_range_commit),
        .wdata    (bus_wdata),
        .gain     (dac_gain),
        .bipolar  (dac_bipolar)
    );

endmodule

// File: rtl/dac_regfront_chk.sv
// Module: dac_regfront_chk
// Property checker bound to dac_regfront. It observes the bus, the outputs
// and the mode bits and checks the timing rules of the register interface.
module dac_regfront_chk
    import dac_regfront_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CODE_W = 12,
    parameter int BUS_W  = 16,
    parameter int ADDR_W = 8
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [ADDR_W-1:0]        bus_addr,
    input logic                     bus_wr,
    input logic                     bus_rd,
    input logic [BUS_W-1:0]         bus_wdata,
    input logic [NUM_CH*CODE_W-1:0] dac_code,
    input logic [NUM_CH-1:0]        dac_gain,
    input logic [NUM_CH-1:0]        dac_bipolar,
    input logic                     out_enable,
    input logic                     staged_mode
);

    // R1: a reset edge leaves every output at zero.
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (dac_code == '0 && dac_gain == '0 && dac_bipolar == '0));

    // R6: with no write and no code commit, codes do not move.
    p_code_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_wr && !(bus_rd && bus_addr == ADDR_W'(MODE_ADDR)))
        |=> $stable(dac_code));

    // R9: range outputs change only after a range commit read.
    p_range_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_addr == ADDR_W'(RANGE_ADDR))
        |=> ($stable(dac_gain) && $stable(dac_bipolar)));

    // R8: writing the mode register with enable low blanks every code.
    p_off_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(MODE_ADDR) && !bus_wdata[EN_BIT])
        |=> (dac_code == '0));

    // R4 and R5: a direct-mode write shows its low code bits next cycle.
    for (genvar c = 0; c < NUM_CH; c++) begin : g_direct
        p_direct_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_addr == ADDR_W'(DATA_BASE + 2 * c)
             && !staged_mode && out_enable)
            |=> (dac_code[c*CODE_W +: CODE_W] == $past(bus_wdata[CODE_W-1:0])));
    end

endmodule

bind dac_regfront dac_regfront_chk #(
    .NUM_CH (NUM_CH),
    .CODE_W (CODE_W),
    .BUS_W  (BUS_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_wr      (bus_wr),
    .bus_rd      (bus_rd),
    .bus_wdata   (bus_wdata),
    .dac_code    (dac_code),
    .dac_gain    (dac_gain),
    .dac_bipolar (dac_bipolar),
    .out_enable  (out_enable),
    .staged_mode (staged_mode)
);

// File: tb/dac_regfront_tb.sv
// Bench: behavioural reference model compared with the outputs every cycle,
// plus directed checks with hand-computed values.
module dac_regfront_tb;

    localparam int NCH = 4;
    localparam int CW  = 12;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [7:0]      bus_addr = '0;
    logic            bus_wr = 1'b0;
    logic            bus_rd = 1'b0;
    logic [15:0]     bus_wdata = '0;
    logic [NCH*CW-1:0] dac_code;
    logic [NCH-1:0]  dac_gain;
    logic [NCH-1:0]  dac_bipolar;

    int checks = 0;
    int failures = 0;

    // Reference model state
    int        m_hold[NCH];
    int        m_live[NCH];
    bit        m_en;
    bit        m_stg;
    bit [15:0] m_stage;
    bit [15:0] m_act;

    always #4 clk = ~clk;

    dac_regfront u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_addr    (bus_addr),
        .bus_wr      (bus_wr),
        .bus_rd      (bus_rd),
        .bus_wdata   (bus_wdata),
        .dac_code    (dac_code),
        .dac_gain    (dac_gain),
        .dac_bipolar (dac_bipolar)
    );

    task automatic check_val(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_step();
        int old_hold[NCH];
        bit old_stg;
        bit [15:0] old_stage;
        if (!rst_n) begin
            for (int c = 0; c < NCH; c++) begin
                m_hold[c] = 0;
                m_live[c] = 0;
            end
            m_en = 0; m_stg = 0; m_stage = '0; m_act = '0;
            return;
        end
        for (int c = 0; c < NCH; c++) old_hold[c] = m_hold[c];
        old_stg = m_stg;
        old_stage = m_stage;
        if (bus_wr) begin
            if (bus_addr == 8'h02) begin
                m_en = bus_wdata[1];
                m_stg = bus_wdata[0];
            end else if (bus_addr == 8'h12) begin
                m_stage = bus_wdata;
            end else begin
                for (int c = 0; c < NCH; c++) begin
                    if (bus_addr == 8'h14 + 2 * c) begin
                        m_hold[c] = int'(bus_wdata & 16'h0FFF);
                        if (!old_stg) m_live[c] = int'(bus_wdata & 16'h0FFF);
                    end
                end
            end
        end
        if (bus_rd && bus_addr == 8'h02 && old_stg) begin
            for (int c = 0; c < NCH; c++) m_live[c] = old_hold[c];
        end
        if (bus_rd && bus_addr == 8'h12) m_act = old_stage;
    endtask

    task automatic compare(input string tag);
        logic [NCH*CW-1:0] e_code;
        logic [NCH-1:0] e_gain;
        logic [NCH-1:0] e_bip;
        for (int c = 0; c < NCH; c++) begin
            e_code[c*CW +: CW] = m_en ? CW'(m_live[c]) : '0;
            e_gain[c] = m_act[11 - c];
            e_bip[c]  = m_act[7 - c];
        end
        check_val(tag, {8'h0, dac_gain, dac_bipolar, dac_code}, {8'h0, e_gain, e_bip, e_code});
    endtask

    // One bus cycle: drive at negedge, model at posedge, compare at next negedge.
    task automatic cyc(input bit w, input bit r, input logic [7:0] a,
                       input logic [15:0] d, input string tag);
        bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        model_step();
        @(negedge clk);
        bus_wr = 0; bus_rd = 0;
        compare(tag);
    endtask

    task automatic idle(input string tag);
        cyc(0, 0, 8'h00, 16'h0, tag);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(8 * 100000);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        @(negedge clk);
        rst_n = 0;
        idle("R1"); idle("R1");
        check_val("R1 code", 64'(dac_code), 64'h0);
        check_val("R1 range", 64'({dac_gain, dac_bipolar}), 64'h0);
        rst_n = 1;
        idle("R1");

        // R3: enable on, direct mode
        cyc(1, 0, 8'h02, 16'hFFF2, "R3");
        // R4, R5: direct write, upper bits dropped
        cyc(1, 0, 8'h14, 16'hF123, "R4");
        check_val("R5 ch0", 64'(dac_code[11:0]), 64'h123);
        cyc(1, 0, 8'h16, 16'h0456, "R4");
        cyc(1, 0, 8'h18, 16'hA789, "R5");
        cyc(1, 0, 8'h1A, 16'h0ABC, "R4");
        check_val("R4 ch3", 64'(dac_code[47:36]), 64'hABC);
        // R2: unmapped write ignored
        cyc(1, 0, 8'h1C, 16'h0FFF, "R2");
        cyc(1, 0, 8'h13, 16'hFFFF, "R2");
        check_val("R2 codes", 64'(dac_code), 64'hABC_789_456_123);

        // R6: staged writes do not move outputs
        cyc(1, 0, 8'h02, 16'h0003, "R3");
        cyc(1, 0, 8'h14, 16'h0111, "R6");
        cyc(1, 0, 8'h16, 16'h0222, "R6");
        cyc(1, 0, 8'h18, 16'h0333, "R6");
        cyc(1, 0, 8'h1A, 16'hF444, "R6");
        check_val("R6 held", 64'(dac_code), 64'hABC_789_456_123);
        // R10: unrelated read does nothing
        cyc(0, 1, 8'h04, 16'h0, "R10");
        check_val("R10 no commit", 64'(dac_code), 64'hABC_789_456_123);
        // R7: commit read updates all four together
        cyc(0, 1, 8'h02, 16'h0, "R7");
        check_val("R7 commit", 64'(dac_code), 64'h444_333_222_111);

        // R8: disable blanks, stored values survive
        cyc(1, 0, 8'h02, 16'h0001, "R8");
        check_val("R8 off", 64'(dac_code), 64'h0);
        cyc(1, 0, 8'h18, 16'h0999, "R8");
        cyc(1, 0, 8'h02, 16'h0003, "R8");
        check_val("R8 back on", 64'(dac_code), 64'h444_333_222_111);
        cyc(0, 1, 8'h02, 16'h0, "R7");
        check_val("R7 after off", 64'(dac_code), 64'h444_999_222_111);

        // R9: range staged until read of 0x12
        cyc(1, 0, 8'h12, 16'h0A50, "R9");
        check_val("R9 before commit", 64'({dac_gain, dac_bipolar}), 64'h0);
        cyc(0, 1, 8'h14, 16'h0, "R10");
        check_val("R10 range", 64'({dac_gain, dac_bipolar}), 64'h0);
        cyc(0, 1, 8'h12, 16'h0, "R9");
        check_val("R9 gain", 64'(dac_gain), 64'h5);
        check_val("R9 bipolar", 64'(dac_bipolar), 64'hA);

        // Mixed traffic against the model
        for (int i = 0; i < 400; i++) begin
            logic [7:0] alist[8] = '{8'h02, 8'h12, 8'h14, 8'h16, 8'h18, 8'h1A, 8'h04, 8'h30};
            logic [7:0] a;
            bit w;
            a = alist[$urandom % 8];
            w = ($urandom % 2) == 1;
            cyc(w, !w, a, 16'($urandom), "R2");
        end

        // R1: reset mid-run clears everything
        rst_n = 0;
        idle("R1");
        check_val("R1 mid reset", 64'({dac_gain, dac_bipolar, dac_code}), 64'h0);
        rst_n = 1;
        idle("R1");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule